// File: doc/BRIEF.md
# Queue Accumulation Scanner

This block takes over the job of polling descriptor queues. A slot sequencer visits the queues one per clock cycle. A fast tier of 32 channels owns one queue each and is visited in a tight loop. A slow tier of 16 channels owns a block of 32 queues each. After every complete pass over the fast tier, exactly one slow-tier channel gets a slot. When a visited channel is enabled, is not waiting for software and has a descriptor pending, the block pops one descriptor. It then writes the address into that channel's list buffer.

Each channel keeps a running entry count against a list size that can be set per channel. A pop that fills the list ends it. In the next cycle the block writes the final count into the list's first slot and holds the scan for that cycle. One cycle later it raises the channel's interrupt. The channel pops nothing more until software acknowledges the interrupt. The acknowledge clears the interrupt and starts a fresh list. Fast-tier channels drive one interrupt line each, meant for a single processor. Slow-tier channels drive their own lines, meant to be broadcast to every processor.

Top module: `qacc_scanner`

## Requirements
- R1: After reset every interrupt is low, every list size is 4, every count is zero, and no pop or list write happens while no enabled channel has a pending queue.
- R2: Fast-tier slots visit channels 0, 1, … 31 on consecutive cycles, then take one slow-tier slot, then start again at 0. Fast channel c owns queue number c.
- R3: Exactly one slow-tier slot follows each fast sweep, so a sweep lasts 33 cycles. Slow channels take their turns in order 0 to 15 and then wrap. Two slow-tier pops never happen in adjacent cycles.
- R4: Slow channel s owns queue numbers 32 + 32·s + k for k = 0..31. In its slot it pops the pending queue with the lowest k.
- R5: A pop writes the popped address to list entry n, where n is the channel's count after the pop. The first pop goes to entry 1. Entries fill in pop order, and the write happens in the same cycle as the pop.
- R6: When the count reaches the list size, the next cycle writes the count to entry 0 and no pop happens in that cycle. The channel's interrupt rises one cycle later. The channel is not popped while its interrupt is high.
- R7: An acknowledge pulse on a channel's bit clears its interrupt on the next cycle. It also resets its count, so the following pop writes entry 1 again.
- R8: A channel whose enable bit is low is never popped, and its queue is left untouched.
- R9: A configuration write sets one channel's list size. `cfg_lo` picks the tier (0 fast, 1 slow), `cfg_chan` the channel and `cfg_size` the size (1..63). Each channel keeps its own size.
- R10: A completed slow-tier list raises only its bit of `lo_irq`, and a completed fast-tier list raises only its bit of `hi_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_en | input | 32 | Fast-tier channel enables |
| lo_en | input | 16 | Slow-tier channel enables |
| hi_pend | input | 32 | Fast-tier queue non-empty flags |
| lo_pend | input | 512 | Slow-tier queue non-empty flags, 32 per channel |
| pop_en | output | 1 | Pop request this cycle |
| pop_q | output | 10 | Queue number being popped |
| pop_addr | input | 32 | Head descriptor address of queue `pop_q` |
| wr_en | output | 1 | List buffer write strobe |
| wr_lo | output | 1 | List tier (0 fast, 1 slow) |
| wr_chan | output | 5 | List channel |
| wr_idx | output | 6 | List entry (0 is the count) |
| wr_data | output | 32 | Address or count written |
| hi_irq | output | 32 | Fast-tier list-ready interrupts |
| lo_irq | output | 16 | Slow-tier list-ready interrupts |
| hi_ack | input | 32 | Fast-tier acknowledge pulses |
| lo_ack | input | 16 | Slow-tier acknowledge pulses |
| cfg_we | input | 1 | List size write strobe |
| cfg_lo | input | 1 | Tier selected for the size write |
| cfg_chan | input | 5 | Channel selected for the size write |
| cfg_size | input | 6 | New list size |

## Verification
One pattern makes every fast queue pending at once. The pop log then shows the strict 0..31 slot order and the single idle slow slot before the loop repeats. A second pattern gives one queue to each slow channel. The 33-cycle spacing and the 0..15 order of the pops separate the round-robin from any burst service. A slow channel with several pending queues shows whether the lowest queue is chosen. Single fast channels with deep queues and varied sizes check the list layout, the header timing, the stop until acknowledge, and that a disabled neighbour is left alone.

// File: rtl/qacc_pkg.sv
package qacc_pkg;
  parameter int QACC_NUM_HI   = 32;
  parameter int QACC_NUM_LO   = 16;
  parameter int QACC_LO_SPAN  = 32;
  parameter int QACC_AW       = 32;
  parameter int QACC_SZW      = 6;
  parameter int QACC_DEF_SIZE = 4;

  typedef enum logic {TIER_HI = 1'b0, TIER_LO = 1'b1} tier_e;
endpackage

// File: rtl/qacc_sweep.sv
module qacc_sweep #(
  parameter int NUM_HI = 32,
  parameter int NUM_LO = 16,
  parameter int HW     = 5,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic          on_lo,
  output logic [HW-1:0] hi_idx,
  output logic [LW-1:0] lo_idx
);
  logic          on_lo_d;
  logic [HW-1:0] hi_d;
  logic [LW-1:0] lo_d;

  always_comb begin
    on_lo_d = on_lo;
    hi_d    = hi_idx;
    lo_d    = lo_idx;
    if (on_lo) begin
      on_lo_d = 1'b0;
      hi_d    = '0;
      lo_d    = (lo_idx == LW'(NUM_LO - 1)) ? '0 : lo_idx + 1'b1;
    end else if (hi_idx == HW'(NUM_HI - 1)) begin
      on_lo_d = 1'b1;
    end else begin
      hi_d = hi_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_lo  <= 1'b0;
      hi_idx <= '0;
      lo_idx <= '0;
    end else if (adv) begin
      on_lo  <= on_lo_d;
      hi_idx <= hi_d;
      lo_idx <= lo_d;
    end
  end
endmodule

// File: rtl/qacc_lo_pick.sv
module qacc_lo_pick #(
  parameter int SPAN = 32,
  parameter int KW   = 5
) (
  input  logic [SPAN-1:0] req,
  output logic            found,
  output logic [KW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = SPAN - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = KW'(k);
      end
    end
  end
endmodule

// File: rtl/qacc_chan_bank.sv
module qacc_chan_bank #(
  parameter int N        = 32,
  parameter int IW       = 5,
  parameter int SZW      = 6,
  parameter int DEF_SIZE = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  sel,
  input  logic           inc,
  input  logic [N-1:0]   ack,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [SZW-1:0] cfg_size,
  output logic [SZW-1:0] cnt_o,
  output logic           hold_o,
  output logic           last_o
);
  logic [N-1:0][SZW-1:0] cnt_all;
  logic [N-1:0][SZW-1:0] size_all;
  logic [N-1:0]          hold_all;

  assign cnt_o  = cnt_all[sel];
  assign hold_o = hold_all[sel];
  assign last_o = ((SZW+1)'(cnt_o) + 1'b1) >= (SZW+1)'(size_all[sel]);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [SZW-1:0] cnt_q, cnt_d, size_q, size_d;
    logic           hold_q, hold_d, hit;

    always_comb begin
      hit    = inc && (sel == IW'(i));
      cnt_d  = cnt_q;
      hold_d = hold_q;
      size_d = size_q;
      if (ack[i]) begin
        cnt_d  = '0;
        hold_d = 1'b0;
      end else if (hit) begin
        cnt_d = cnt_q + 1'b1;
        if (last_o) hold_d = 1'b1;
      end
      if (cfg_we && (cfg_idx == IW'(i))) size_d = cfg_size;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
        size_q <= SZW'(DEF_SIZE);
      end else begin
        cnt_q  <= cnt_d;
        hold_q <= hold_d;
        size_q <= size_d;
      end
    end

    assign cnt_all[i]  = cnt_q;
    assign size_all[i] = size_q;
    assign hold_all[i] = hold_q;
  end
endmodule

// File: rtl/qacc_scanner.sv
module qacc_scanner
  import qacc_pkg::*;
#(
  parameter int NUM_HI   = QACC_NUM_HI,
  parameter int NUM_LO   = QACC_NUM_LO,
  parameter int LO_SPAN  = QACC_LO_SPAN,
  parameter int AW       = QACC_AW,
  parameter int SZW      = QACC_SZW,
  parameter int DEF_SIZE = QACC_DEF_SIZE,
  localparam int HW = $clog2(NUM_HI),
  localparam int LW = $clog2(NUM_LO),
  localparam int KW = $clog2(LO_SPAN),
  localparam int CW = (HW > LW) ? HW : LW,
  localparam int QW = $clog2(NUM_HI + NUM_LO * LO_SPAN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_HI-1:0]         hi_en,
  input  logic [NUM_LO-1:0]         lo_en,
  input  logic [NUM_HI-1:0]         hi_pend,
  input  logic [NUM_LO*LO_SPAN-1:0] lo_pend,
  output logic                      pop_en,
  output logic [QW-1:0]             pop_q,
  input  logic [AW-1:0]             pop_addr,
  output logic                      wr_en,
  output logic                      wr_lo,
  output logic [CW-1:0]             wr_chan,
  output logic [SZW-1:0]            wr_idx,
  output logic [AW-1:0]             wr_data,
  output logic [NUM_HI-1:0]         hi_irq,
  output logic [NUM_LO-1:0]         lo_irq,
  input  logic [NUM_HI-1:0]         hi_ack,
  input  logic [NUM_LO-1:0]         lo_ack,
  input  logic                      cfg_we,
  input  logic                      cfg_lo,
  input  logic [CW-1:0]             cfg_chan,
  input  logic [SZW-1:0]            cfg_size
);
  logic on_lo, found, go, cur_last;
  logic [HW-1:0] hi_idx;
  logic [LW-1:0] lo_idx;
  logic [KW-1:0] lo_k;
  logic [LO_SPAN-1:0] lo_slice;
  logic [SZW-1:0] hi_cnt, lo_cnt, cur_cnt;
  logic hi_hold, lo_hold, hi_last, lo_last;

  // Pending header write, one cycle after a list fills
  logic           hdr_vld_q, hdr_vld_d;
  tier_e          hdr_tier_q, hdr_tier_d;
  logic [CW-1:0]  hdr_ch_q, hdr_ch_d;
  logic [SZW-1:0] hdr_cnt_q, hdr_cnt_d;
  logic [NUM_HI-1:0] hi_irq_d;
  logic [NUM_LO-1:0] lo_irq_d;

  qacc_sweep #(.NUM_HI(NUM_HI), .NUM_LO(NUM_LO), .HW(HW), .LW(LW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .adv(!hdr_vld_q),
    .on_lo(on_lo), .hi_idx(hi_idx), .lo_idx(lo_idx)
  );

  assign lo_slice = lo_pend[int'(lo_idx)*LO_SPAN +: LO_SPAN];

  qacc_lo_pick #(.SPAN(LO_SPAN), .KW(KW)) u_pick (
    .req(lo_slice), .found(found), .idx(lo_k)
  );

  qacc_chan_bank #(.N(NUM_HI), .IW(HW), .SZW(SZW), .DEF_SIZE(DEF_SIZE)) u_hi_bank (
    .clk(clk), .rst_n(rst_n), .sel(hi_idx), .inc(go && !on_lo), .ack(hi_ack),
    .cfg_we(cfg_we && !cfg_lo), .cfg_idx(cfg_chan[HW-1:0]), .cfg_size(cfg_size),
    .cnt_o(hi_cnt), .hold_o(hi_hold), .last_o(hi_last)
  );

  qacc_chan_bank #(.N(NUM_LO), .IW(LW), .SZW(SZW), .DEF_SIZE(DEF_SIZE)) u_lo_bank (
    .clk(clk), .rst_n(rst_n), .sel(lo_idx), .inc(go && on_lo), .ack(lo_ack),
    .cfg_we(cfg_we && cfg_lo), .cfg_idx(cfg_chan[LW-1:0]), .cfg_size(cfg_size),
    .cnt_o(lo_cnt), .hold_o(lo_hold), .last_o(lo_last)
  );

  always_comb begin
    if (on_lo) go = lo_en[lo_idx] && !lo_hold && found;
    else       go = hi_en[hi_idx] && !hi_hold && hi_pend[hi_idx];
    go       = go && !hdr_vld_q;
    cur_cnt  = on_lo ? lo_cnt  : hi_cnt;
    cur_last = on_lo ? lo_last : hi_last;
  end

  assign pop_en = go;
  assign pop_q  = on_lo ? (QW'(NUM_HI) + QW'(lo_idx) * QW'(LO_SPAN) + QW'(lo_k))
                        : QW'(hi_idx);

  assign wr_en   = go || hdr_vld_q;
  assign wr_lo   = hdr_vld_q ? (hdr_tier_q == TIER_LO) : on_lo;
  assign wr_chan = hdr_vld_q ? hdr_ch_q : (on_lo ? CW'(lo_idx) : CW'(hi_idx));
  assign wr_idx  = hdr_vld_q ? '0 : cur_cnt + 1'b1;
  assign wr_data = hdr_vld_q ? AW'(hdr_cnt_q) : pop_addr;

  always_comb begin
    hdr_vld_d  = go && cur_last;
    hdr_tier_d = on_lo ? TIER_LO : TIER_HI;
    hdr_ch_d   = on_lo ? CW'(lo_idx) : CW'(hi_idx);
    hdr_cnt_d  = cur_cnt + 1'b1;
    hi_irq_d   = hi_irq & ~hi_ack;
    lo_irq_d   = lo_irq & ~lo_ack;
    if (hdr_vld_q && hdr_tier_q == TIER_HI) hi_irq_d[hdr_ch_q[HW-1:0]] = 1'b1;
    if (hdr_vld_q && hdr_tier_q == TIER_LO) lo_irq_d[hdr_ch_q[LW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_vld_q  <= 1'b0;
      hdr_tier_q <= TIER_HI;
      hdr_ch_q   <= '0;
      hdr_cnt_q  <= '0;
      hi_irq     <= '0;
      lo_irq     <= '0;
    end else begin
      hdr_vld_q <= hdr_vld_d;
      if (hdr_vld_d) begin
        hdr_tier_q <= hdr_tier_d;
        hdr_ch_q   <= hdr_ch_d;
        hdr_cnt_q  <= hdr_cnt_d;
      end
      hi_irq <= hi_irq_d;
      lo_irq <= lo_irq_d;
    end
  end
endmodule

// File: rtl/qacc_scanner_chk.sv
module qacc_scanner_chk #(
  parameter int NUM_HI = 32,
  parameter int NUM_LO = 16,
  parameter int LO_SPAN = 32,
  parameter int AW = 32,
  parameter int SZW = 6,
  parameter int HW = 5,
  parameter int CW = 5,
  parameter int QW = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_HI-1:0]         hi_en,
  input logic                      pop_en,
  input logic [QW-1:0]             pop_q,
  input logic [AW-1:0]             pop_addr,
  input logic                      wr_en,
  input logic                      wr_lo,
  input logic [CW-1:0]             wr_chan,
  input logic [SZW-1:0]            wr_idx,
  input logic [AW-1:0]             wr_data,
  input logic [NUM_HI-1:0]         hi_irq,
  input logic [NUM_HI-1:0]         hi_ack
);
  logic lo_pop, hi_pop, hdr_wr;
  assign lo_pop = pop_en && (pop_q >= QW'(NUM_HI));
  assign hi_pop = pop_en && (pop_q <  QW'(NUM_HI));
  assign hdr_wr = wr_en && (wr_idx == '0);

  // R5
  pop_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (wr_en && wr_data == pop_addr && wr_idx != '0));

  // R6
  hdr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr |-> !pop_en);

  // R6
  hdr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_wr && !wr_lo) |=> hi_irq[$past(wr_chan[HW-1:0])]);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pop |-> !hi_irq[pop_q[HW-1:0]]);

  // R3
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_pop |=> !lo_pop);

  // R8
  hi_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pop |-> hi_en[pop_q[HW-1:0]]);

  // R7
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hi_irq & hi_ack)) |=> ((hi_irq & $past(hi_irq & hi_ack)) == '0));
endmodule

bind qacc_scanner qacc_scanner_chk #(
  .NUM_HI(NUM_HI), .NUM_LO(NUM_LO), .LO_SPAN(LO_SPAN), .AW(AW), .SZW(SZW),
  .HW(HW), .CW(CW), .QW(QW)
) u_chk (.*);

// File: tb/qacc_scanner_tb_top.sv
module qacc_scanner_tb_top;
  localparam int NH = 32, NL = 16, SP = 32, AW = 32, SZW = 6, CW = 5, QW = 10;
  localparam int NQ = NH + NL * SP;

  logic clk = 1'b0;
  logic rst_n;
  logic [NH-1:0] hi_en, hi_pend, hi_irq, hi_ack;
  logic [NL-1:0] lo_en, lo_irq, lo_ack;
  logic [NL*SP-1:0] lo_pend;
  logic pop_en, wr_en, wr_lo, cfg_we, cfg_lo;
  logic [QW-1:0] pop_q;
  logic [AW-1:0] pop_addr, wr_data;
  logic [CW-1:0] wr_chan, cfg_chan;
  logic [SZW-1:0] wr_idx, cfg_size;

  int depth [NQ];
  int head [NQ];
  int plog [0:1023];
  int ptime [0:1023];
  int np, htime, cyc;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [31:0] lst [0:1][0:31][0:63];

  always #2.5 clk = ~clk;

  qacc_scanner dut_i (.*);

  function automatic logic [31:0] addr_of(input int q, input int n);
    return (32'(q) << 16) | 32'(n);
  endfunction

  always_comb begin
    for (int q = 0; q < NH; q++) hi_pend[q] = head[q] < depth[q];
    for (int i = 0; i < NL * SP; i++) lo_pend[i] = head[NH + i] < depth[NH + i];
    pop_addr = addr_of(int'(pop_q), head[int'(pop_q)]);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pop_en) begin
        plog[np] = int'(pop_q);
        ptime[np] = cyc;
        np = np + 1;
        head[int'(pop_q)] = head[int'(pop_q)] + 1;
      end
      if (wr_en) begin
        lst[wr_lo][wr_chan][wr_idx] = wr_data;
        if (wr_idx == '0) htime = cyc;
      end
    end
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hi_en = '0; lo_en = '0; hi_ack = '0; lo_ack = '0;
    cfg_we = 1'b0; cfg_lo = 1'b0; cfg_chan = '0; cfg_size = '0;
    for (int q = 0; q < NQ; q++) begin depth[q] = 0; head[q] = 0; end
    np = 0; htime = -1; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_size(input logic lo, input int ch, input int sz);
    cfg_we = 1'b1; cfg_lo = lo; cfg_chan = CW'(ch); cfg_size = SZW'(sz);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(hi_irq == '0 && lo_irq == '0, "R1 irq", longint'(hi_irq), 0);
    chk(!pop_en && !wr_en, "R1 idle", longint'({pop_en, wr_en}), 0);
    run(80);
    chk(np == 0, "R1 no pops", np, 0);
  endtask

  task automatic t_hi_order();
    bit ok = 1'b1;
    do_reset();
    for (int q = 0; q < NH; q++) depth[q] = 1;
    hi_en = '1;
    run(80);
    for (int i = 0; i < NH; i++)
      if (plog[i] != i || ptime[i] != ptime[0] + i) ok = 1'b0;
    chk(ok, "R2 order", plog[31], 31);
    chk(np == NH, "R2 count", np, NH);
  endtask

  task automatic t_lo_rr();
    bit ok = 1'b1;
    do_reset();
    for (int s = 0; s < NL; s++) depth[NH + s * SP] = 1;
    lo_en = '1;
    run(33 * 17 + 10);
    for (int i = 0; i < NL; i++)
      if (plog[i] != NH + i * SP || ptime[i] != ptime[0] + 33 * i) ok = 1'b0;
    chk(ok, "R3 round robin", ptime[1] - ptime[0], 33);
    chk(np == NL, "R3 count", np, NL);
  endtask

  task automatic t_list();
    bit ok = 1'b1;
    do_reset();
    depth[3] = 6;
    hi_en = 32'h1 << 3;
    run(220);
    chk(lst[0][3][0] == 4, "R5 header", lst[0][3][0], 4);
    for (int i = 1; i <= 4; i++) if (lst[0][3][i] != addr_of(3, i - 1)) ok = 1'b0;
    chk(ok, "R5 entries", lst[0][3][4], addr_of(3, 3));
    chk(htime == ptime[3] + 1, "R6 header cycle", htime, ptime[3] + 1);
    chk(hi_irq == (32'h1 << 3), "R6 irq", longint'(hi_irq), 8);
    chk(head[3] == 4, "R6 stop", head[3], 4);
    hi_ack = 32'h1 << 3;
    @(negedge clk);
    hi_ack = '0;
    chk(hi_irq == '0, "R7 irq clear", longint'(hi_irq), 0);
    run(150);
    chk(head[3] == 6, "R7 resume", head[3], 6);
    chk(lst[0][3][1] == addr_of(3, 4) && lst[0][3][2] == addr_of(3, 5),
        "R7 restart", lst[0][3][1], addr_of(3, 4));
    chk(hi_irq == '0, "R7 no irq", longint'(hi_irq), 0);
  endtask

  task automatic t_lo_pick();
    do_reset();
    set_size(1'b1, 2, 3);
    depth[NH + 2 * SP + 9] = 1;
    depth[NH + 2 * SP + 30] = 1;
    depth[NH + 2 * SP + 5] = 1;
    lo_en = 16'h1 << 2;
    run(2000);
    chk(np == 3 && plog[0] == 101 && plog[1] == 105 && plog[2] == 126,
        "R4 lowest first", plog[0], 101);
    chk(lst[1][2][0] == 3, "R9 lo size", lst[1][2][0], 3);
    chk(lo_irq == (16'h1 << 2), "R10 lo irq", longint'(lo_irq), 4);
    chk(hi_irq == '0, "R10 hi quiet", longint'(hi_irq), 0);
  endtask

  task automatic t_disable();
    do_reset();
    set_size(1'b0, 7, 2);
    set_size(1'b0, 8, 2);
    depth[7] = 2; depth[8] = 2;
    hi_en = 32'h1 << 8;
    run(150);
    chk(head[7] == 0, "R8 untouched", head[7], 0);
    chk(hi_irq == (32'h1 << 8), "R8 neighbour", longint'(hi_irq), 256);
  endtask

  task automatic t_sizes();
    do_reset();
    set_size(1'b0, 0, 1);
    set_size(1'b0, 1, 3);
    depth[0] = 5; depth[1] = 5;
    hi_en = 32'h3;
    run(300);
    chk(head[0] == 1 && lst[0][0][0] == 1, "R9 size 1", head[0], 1);
    chk(head[1] == 3 && lst[0][1][0] == 3, "R9 size 3", head[1], 3);
    chk(hi_irq == 32'h3, "R9 irqs", longint'(hi_irq), 3);
  endtask

  initial begin
    t_reset();
    t_hi_order();
    t_lo_rr();
    t_list();
    t_lo_pick();
    t_disable();
    t_sizes();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule